// File: doc/BRIEF.md
# Three-Engine Longest-Prefix Lookup Dispatcher

This block takes 32-bit IPv4 destination addresses and returns one 16-bit next hop for each, in arrival order. Addresses enter a small input queue. A dispatcher hands them in strict rotation to three identical lookup engines. Each engine walks a stride table in external synchronous memory, four address bits per step, starting from the most significant nibble. It keeps the most recent valid next hop it has seen along the path. Results are retired in the same rotation into an output queue, so a short lookup that finishes early waits behind a longer lookup that started before it.

The three engines share one memory read port without any arbitration. A free-running five-cycle slot counter gives engine k the port in slot k. The engine registers the returned word in slot k+1, spends three cycles computing, and registers its next read address by the end of slot k+4. Lookups start only after the memory port has been granted. An address is taken from the input queue only when the next engine in rotation is idle and the output queue has room for every result still outstanding.

Top module: `lookup_dispatch`

## Requirements
- R1: While reset is held, `in_ready` is 1 and `out_avail`, `mem_rd` and `mem_req` are 0. `mem_req` is 1 from the second cycle after reset is released.
- R2: No memory read is issued until `mem_gnt` has been seen high. Addresses written before that point are kept and looked up once the grant arrives.
- R3: A single lookup reads memory once every 5 cycles. Reads by the three engines fall in distinct fixed slots of that 5-cycle period, and at most one read is issued per cycle.
- R4: A read address is {node, nibble}: the node number in the upper AW-4 bits and the current 4-bit address nibble in the low 4 bits. The first read of a lookup uses node 0 and address bits 31:28. Each later read uses the next lower nibble.
- R5: In a memory word, bit 31 marks a valid next hop, bits 15:0 hold that hop, and bits 30:16 hold the child node number. The result is the hop of the last valid word read along the path, or 0 if no word read was valid.
- R6: A walk ends after the word whose child field is 0, or after the eighth read (all 32 address bits consumed), whichever comes first.
- R7: Next hops leave the output queue in the order their addresses were written, even when a later lookup needs fewer reads.
- R8: An address is not removed from the input queue unless the output queue can hold every result still in flight. With `out_pop` held low, no result is lost, and the head of the output queue holds steady.
- R9: The input queue holds IDEPTH addresses. When it is full, `in_ready` is 0 and a write is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Write an address into the input queue |
| in_addr | input | 32 | IPv4 destination address |
| in_ready | output | 1 | Input queue has space |
| out_pop | input | 1 | Remove the head result |
| out_hop | output | 16 | Next hop at the head of the output queue |
| out_avail | output | 1 | Output queue is not empty |
| mem_req | output | 1 | Request for the memory port |
| mem_gnt | input | 1 | Memory port granted |
| mem_rd | output | 1 | Read strobe this cycle |
| mem_addr | output | AW | Read address |
| mem_rdata | input | 32 | Read data, one cycle after the address |

## Verification
Assertions check the following on every cycle:
- reads stay inside the three engine slots and never come before the grant;
- the output queue plus the in-flight lookups never exceed its depth;
- a full input queue deasserts ready;
- retirement steps through the engines in rotation;
- the output head stays stable while it is not popped.

Only the bench scenarios can show the following, because each depends on table contents and on the exact read sequence:
- the result values;
- the stopping rules on a null child and on address exhaustion;
- the read address sequence and its 5-cycle spacing;
- arrival-order delivery when a deep lookup precedes shallow ones.

// File: rtl/lookup_dispatch.sv
module lookup_dispatch #(
  parameter int AW = 10,
  parameter int IDEPTH = 4,
  parameter int ODEPTH = 4,
  parameter logic [15:0] DEF_HOP = 16'h0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic [31:0]   in_addr,
  output logic          in_ready,
  input  logic          out_pop,
  output logic [15:0]   out_hop,
  output logic          out_avail,
  output logic          mem_req,
  input  logic          mem_gnt,
  output logic          mem_rd,
  output logic [AW-1:0] mem_addr,
  input  logic [31:0]   mem_rdata
);
  localparam int NENG = 3;
  localparam int PERIOD = 5;
  localparam int NW = AW - 4;
  localparam int IPW = $clog2(IDEPTH);
  localparam int OPW = $clog2(ODEPTH);

  logic          owned;
  logic [2:0]    cnt;
  logic [31:0]   ifq [IDEPTH];
  logic [IPW-1:0] iwp, irp;
  logic [IPW:0]  icnt;
  logic [15:0]   ofq [ODEPTH];
  logic [OPW-1:0] owp, orp;
  logic [OPW:0]  ocnt;

  logic [NENG-1:0] busy, done, iss;
  logic [31:0]   key  [NENG];
  logic [31:0]   dat  [NENG];
  logic [NW-1:0] node [NENG];
  logic [2:0]    step [NENG];
  logic [15:0]   best [NENG];
  logic [1:0]    wsel, rsel;
  logic [2:0]    nbusy;
  logic          push_in, dispatch, retire, pop_out;

  assign in_ready  = (icnt != IDEPTH[IPW:0]);
  assign push_in   = in_valid && in_ready;
  assign out_avail = (ocnt != '0);
  assign out_hop   = ofq[orp];
  assign pop_out   = out_pop && out_avail;
  assign retire    = busy[rsel] && done[rsel];
  assign dispatch  = owned && (icnt != '0) && !busy[wsel] &&
                     ((int'(ocnt) + int'(nbusy)) < ODEPTH);

  always_comb begin
    nbusy = '0;
    for (int e = 0; e < NENG; e++) nbusy = nbusy + {2'b00, busy[e]};
  end

  always_comb begin
    mem_rd = 1'b0;
    mem_addr = '0;
    for (int e = 0; e < NENG; e++)
      if (cnt == 3'(e) && busy[e] && !done[e]) begin
        mem_rd = 1'b1;
        mem_addr = {node[e], key[e][31:28]};
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owned <= 1'b0;
      mem_req <= 1'b0;
      cnt <= '0;
      wsel <= '0;
      rsel <= '0;
    end else begin
      mem_req <= 1'b1;
      if (mem_req && mem_gnt) owned <= 1'b1;
      cnt <= (cnt == 3'(PERIOD - 1)) ? 3'd0 : cnt + 3'd1;
      if (dispatch) wsel <= (wsel == 2'(NENG - 1)) ? 2'd0 : wsel + 2'd1;
      if (retire)   rsel <= (rsel == 2'(NENG - 1)) ? 2'd0 : rsel + 2'd1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      iwp <= '0;
      irp <= '0;
      icnt <= '0;
    end else begin
      if (push_in) begin
        ifq[iwp] <= in_addr;
        iwp <= (iwp == IPW'(IDEPTH - 1)) ? '0 : iwp + 1'b1;
      end
      if (dispatch) irp <= (irp == IPW'(IDEPTH - 1)) ? '0 : irp + 1'b1;
      icnt <= icnt + (push_in ? 1'b1 : 1'b0) - (dispatch ? 1'b1 : 1'b0);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      owp <= '0;
      orp <= '0;
      ocnt <= '0;
    end else begin
      if (retire) begin
        ofq[owp] <= best[rsel];
        owp <= (owp == OPW'(ODEPTH - 1)) ? '0 : owp + 1'b1;
      end
      if (pop_out) orp <= (orp == OPW'(ODEPTH - 1)) ? '0 : orp + 1'b1;
      ocnt <= ocnt + (retire ? 1'b1 : 1'b0) - (pop_out ? 1'b1 : 1'b0);
    end
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < NENG; e++) begin
      if (!rst_n) begin
        busy[e] <= 1'b0;
        done[e] <= 1'b0;
        iss[e]  <= 1'b0;
        key[e]  <= '0;
        dat[e]  <= '0;
        node[e] <= '0;
        step[e] <= '0;
        best[e] <= DEF_HOP;
      end else if (dispatch && wsel == 2'(e)) begin
        busy[e] <= 1'b1;
        done[e] <= 1'b0;
        iss[e]  <= 1'b0;
        key[e]  <= ifq[irp];
        node[e] <= '0;
        step[e] <= '0;
        best[e] <= DEF_HOP;
      end else if (retire && rsel == 2'(e)) begin
        busy[e] <= 1'b0;
        done[e] <= 1'b0;
      end else if (busy[e] && !done[e]) begin
        if (cnt == 3'(e)) iss[e] <= 1'b1;
        if (iss[e] && cnt == 3'((e + 1) % PERIOD)) dat[e] <= mem_rdata;
        if (iss[e] && cnt == 3'((e + 4) % PERIOD)) begin
          iss[e] <= 1'b0;
          if (dat[e][31]) best[e] <= dat[e][15:0];
          if (dat[e][30:16] == '0 || step[e] == 3'd7) done[e] <= 1'b1;
          else begin
            node[e] <= dat[e][16 +: NW];
            step[e] <= step[e] + 3'd1;
            key[e]  <= {key[e][27:0], 4'h0};
          end
        end
      end
    end
  end
endmodule

module lookup_dispatch_chk #(
  parameter int IDEPTH = 4,
  parameter int ODEPTH = 4
) (
  input logic clk,
  input logic rst_n,
  input logic owned,
  input logic mem_rd,
  input logic [2:0] cnt,
  input logic [$clog2(ODEPTH):0] ocnt,
  input logic [$clog2(IDEPTH):0] icnt,
  input logic [2:0] nbusy,
  input logic in_ready,
  input logic out_avail,
  input logic out_pop,
  input logic [15:0] out_hop,
  input logic retire,
  input logic [1:0] rsel
);
  p_no_read_before_grant_r2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> owned);
  p_slot_window_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |-> (cnt < 3'd3));
  p_room_reserved_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(ocnt) + int'(nbusy)) <= ODEPTH);
  p_full_blocks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(icnt) == IDEPTH) |-> !in_ready);
  p_retire_rotation_r7: assert property (@(posedge clk) disable iff (!rst_n)
    retire |=> rsel == (($past(rsel) == 2'd2) ? 2'd0 : $past(rsel) + 2'd1));
  p_head_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_avail && !out_pop) |=> (out_avail && $stable(out_hop)));
endmodule

bind lookup_dispatch lookup_dispatch_chk #(.IDEPTH(IDEPTH), .ODEPTH(ODEPTH)) u_chk (.*);

// File: tb/tb_lookup_dispatch.sv
`timescale 1ns/1ps
module tb_lookup_dispatch;
  localparam int AW = 10;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_pop = 1'b0, mem_gnt = 1'b0;
  logic [31:0] in_addr = '0, mem_rdata = '0;
  logic in_ready, out_avail, mem_req, mem_rd;
  logic [15:0] out_hop;
  logic [AW-1:0] mem_addr;

  lookup_dispatch #(.AW(AW)) dut (.*);

  always #4 clk = ~clk;

  logic [31:0] mem [1 << AW];
  always @(posedge clk) mem_rdata <= mem[mem_addr];

  int checks = 0, fails = 0, cyc = 0, rd_n = 0;
  int rd_cyc [16];
  logic [AW-1:0] rd_adr [16];

  always @(negedge clk) begin
    cyc++;
    if (mem_rd) begin
      if (rd_n < 16) begin rd_cyc[rd_n] = cyc; rd_adr[rd_n] = mem_addr; end
      rd_n++;
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic put(input int nd, input int nib, input bit v, input int ch, input int hop);
    mem[nd * 16 + nib] = {v, 15'(ch), 16'(hop)};
  endtask

  function automatic logic [15:0] ref_hop(input logic [31:0] a);
    int nd = 0;
    logic [15:0] b = 16'h0;
    for (int s = 0; s < 8; s++) begin
      logic [31:0] w = mem[nd * 16 + int'(a[31 - 4*s -: 4])];
      if (w[31]) b = w[15:0];
      if (w[30:16] == 0) break;
      nd = int'(w[21:16]);
    end
    return b;
  endfunction

  task automatic push(input logic [31:0] a);
    @(negedge clk);
    in_valid = 1'b1; in_addr = a;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic push_wait(input logic [31:0] a);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1; in_addr = a;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic pop_expect(input logic [15:0] exp, input string tag);
    int t = 0;
    @(negedge clk);
    while (!out_avail && t < 400) begin @(negedge clk); t++; end
    chk(out_avail && out_hop === exp, tag, out_hop, exp);
    out_pop = 1'b1;
    @(negedge clk);
    out_pop = 1'b0;
  endtask

  localparam logic [31:0] A_ = 32'h0ABAC000, B_ = 32'hDA800000, C_ = 32'h80000000,
                          D_ = 32'h0A000000, E_ = 32'hFFFFFFFF, F_ = 32'hF0000000;

  task automatic t_reset;
    chk(in_ready === 1'b1, "R1 in_ready in reset", in_ready, 1);
    chk(out_avail === 1'b0, "R1 out_avail in reset", out_avail, 0);
    chk(mem_rd === 1'b0, "R1 mem_rd in reset", mem_rd, 0);
    chk(mem_req === 1'b0, "R1 mem_req in reset", mem_req, 0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk); @(negedge clk);
    chk(mem_req === 1'b1, "R1 mem_req after reset", mem_req, 1);
  endtask

  task automatic t_grant_and_full;
    rd_n = 0;
    push(A_); push(B_); push(C_); push(D_);
    chk(in_ready === 1'b0, "R9 in_ready low when full", in_ready, 0);
    push(E_);
    repeat (30) @(negedge clk);
    chk(rd_n == 0, "R2 no reads before grant", rd_n, 0);
    chk(out_avail === 1'b0, "R2 no results before grant", out_avail, 0);
    mem_gnt = 1'b1;
    pop_expect(16'h0033, "R2 R5 first after grant");
    pop_expect(16'h0044, "R5 single-level match");
    pop_expect(16'h0000, "R5 default when no valid word");
    pop_expect(16'h0022, "R5 keeps last valid on null path");
    repeat (60) @(negedge clk);
    chk(out_avail === 1'b0, "R9 write while full ignored", out_avail, 0);
  endtask

  task automatic t_schedule;
    rd_n = 0;
    push(A_);
    pop_expect(ref_hop(A_), "R5 ref lookup");
    chk(rd_n == 4, "R6 reads until null child", rd_n, 4);
    chk(rd_adr[0] == 10'h000, "R4 first address", rd_adr[0], 10'h000);
    chk(rd_adr[1] == 10'h01A, "R4 second address", rd_adr[1], 10'h01A);
    chk(rd_adr[2] == 10'h02B, "R4 third address", rd_adr[2], 10'h02B);
    chk(rd_adr[3] == 10'h03A, "R4 fourth address", rd_adr[3], 10'h03A);
    for (int i = 1; i < 4; i++)
      chk(rd_cyc[i] - rd_cyc[i-1] == 5, "R3 read spacing", rd_cyc[i] - rd_cyc[i-1], 5);
  endtask

  task automatic t_deep;
    rd_n = 0;
    push(E_);
    pop_expect(16'h0077, "R6 stops after eighth stride");
    chk(rd_n == 8, "R6 eight reads", rd_n, 8);
    push(F_);
    pop_expect(16'h0070, "R5 root hop kept");
  endtask

  task automatic t_order;
    push(E_); push(B_); push(C_); push(A_);
    pop_expect(16'h0077, "R7 deep lookup first");
    pop_expect(16'h0044, "R7 shallow lookup waits");
    pop_expect(16'h0000, "R7 third in order");
    pop_expect(16'h0033, "R7 fourth in order");
  endtask

  task automatic t_backpressure;
    logic [31:0] seq [8];
    seq[0] = A_; seq[1] = B_; seq[2] = E_; seq[3] = C_;
    seq[4] = D_; seq[5] = F_; seq[6] = B_; seq[7] = E_;
    for (int i = 0; i < 8; i++) push_wait(seq[i]);
    repeat (150) @(negedge clk);
    chk(in_ready === 1'b0, "R8 input held while output full", in_ready, 0);
    chk(out_avail === 1'b1, "R8 results waiting", out_avail, 1);
    for (int i = 0; i < 8; i++) pop_expect(ref_hop(seq[i]), "R8 R7 no loss under backpressure");
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = '0;
    put(0, 4'h0, 1, 1, 16'h0011);
    put(1, 4'hA, 1, 2, 16'h0022);
    put(2, 4'hB, 0, 3, 0);
    put(3, 4'hA, 1, 0, 16'h0033);
    put(0, 4'hD, 1, 0, 16'h0044);
    put(0, 4'h8, 0, 0, 0);
    put(0, 4'hF, 1, 10, 16'h0070);
    for (int n = 10; n < 16; n++) put(n, 4'hF, 0, n + 1, 0);
    put(16, 4'hF, 1, 20, 16'h0077);
    put(20, 4'hF, 1, 0, 16'h0099);
    repeat (3) @(negedge clk);
    t_reset();
    t_grant_and_full();
    t_schedule();
    t_deep();
    t_order();
    t_backpressure();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    checks++; fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule